// File: doc/BRIEF.md
# Quad-Data-Rate Burst-of-Two SRAM Core

This block is a synthesizable device-side model of a synchronous static memory that has one write data port and one read data port, each running at double data rate. A single shared address bus also runs at double data rate. The rising edge of `clk` carries the read address and the falling edge carries the write address. Every access moves a burst of two words, one per clock edge. So one read burst and one write burst can complete in every clock cycle, which gives four word transfers per cycle.

The host drives `rd_n` and `wr_n` low before a rising edge to request an access. It drives the first write word and its byte-write mask for the rising edge, then the write address, second word and second mask for the falling edge. Each address selects a two-word location, and the burst supplies the lowest word index itself. Read data comes back on `rdata`, one word per clock phase. It is framed by `rvalid` and by a complementary pair of echo clocks. A read always sees every write accepted in earlier cycles, including writes still waiting in the write pipeline. It never sees the write accepted in its own cycle, because the read address comes first in that cycle.

Top module: `qdr_b2_sram`

## Requirements
- R1: While `rst_n` is low, and after it is released until the first read burst, `rvalid` is 0 and `rdata` is all zeros.
- R2: A read requested at rising edge R puts the low word (bits [DW-1:0] of the location) on `rdata` during the low phase after rising edge R+1. It puts the high word on `rdata` during the high phase after rising edge R+2. `rvalid` is 1 in exactly those two phases.
- R3: The read address is taken at the rising edge and the write address at the falling edge of the same cycle, so one cycle may read one location and write a different one.
- R4: `rd_n` and `wr_n` are sampled only at rising edges. Driving them low only during the high phase starts no read output and changes no stored data.
- R5: Byte lane i of a word is bits [9i+8:9i] (DW=18, BW=2). Lane i is written only when `bw_n[i]` is 0 for that word's edge. The first word uses the mask sampled at the rising edge and the second word uses the mask sampled at the falling edge.
- R6: When a read and a write hit the same location in one cycle, the read returns the contents from before that write.
- R7: A read issued in the cycle right after a write to the same location returns the newly merged data for both words, including unwritten lanes kept from before.
- R8: A cycle with both enables high changes no stored data. Whenever no burst is driving the output, `rdata` is all zeros.
- R9: `echo_p` is high in the high phase and low in the low phase of `clk`, and `echo_n` is always its complement.
- R10: Reads in consecutive cycles produce an unbroken stream of valid phases in request order.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Input clock; both edges sample inputs |
| rst_n | input | 1 | Asynchronous active-low reset of control state |
| rd_n | input | 1 | Active-low read request, sampled at rising edge |
| wr_n | input | 1 | Active-low write request, sampled at rising edge |
| addr | input | AW | Read address at rising edge, write address at falling edge |
| wdata | input | DW | Write word: first at rising edge, second at falling edge |
| bw_n | input | BW | Active-low byte-write mask for the word on the same edge |
| rdata | output | DW | Read burst words, one per clock phase |
| rvalid | output | 1 | High while `rdata` carries a read word |
| echo_p | output | 1 | Echo clock aligned with output data phases |
| echo_n | output | 1 | Complement of `echo_p` |

## Verification
The two words of a read made at rising edge R are due in the low phase after edge R+1 and the high phase after edge R+2. This is two register stages (address, fetch) plus one launch register on the matching edge. The bench counts rising edges and files each expectation under the phase index where it falls due, keeping a program-order shadow of the array so that same-cycle and next-cycle hazards take their values arithmetically. A monitor samples every phase three time units after its edge, well clear of both clock edges. In each phase it compares `rvalid`, `rdata` and the echo pair against the entry filed for that phase, and an empty entry means idle zeros.

// File: rtl/qdr_pkg.sv
package qdr_pkg;

   localparam int unsigned MAX_W     = 72;
   localparam int unsigned MAX_LANES = 8;

   typedef logic [MAX_W-1:0]     wide_t;
   typedef logic [MAX_LANES-1:0] lanes_t;

   // Per-lane merge: a lane whose keep_n bit is 0 takes the new value.
   function automatic wide_t lane_merge(input wide_t       old_w,
                                        input wide_t       new_w,
                                        input lanes_t      keep_n,
                                        input int unsigned lane_w);
      wide_t r;
      r = old_w;
      for (int unsigned i = 0; i < MAX_W; i++) begin
         if (!keep_n[3'((i / lane_w) % MAX_LANES)])
            r[7'(i)] = new_w[7'(i)];
      end
      return r;
   endfunction

endpackage

// File: rtl/qdr_wr_capture.sv
module qdr_wr_capture #(
   parameter int unsigned AW = 8,
   parameter int unsigned DW = 18,
   parameter int unsigned BW = 2,
   parameter bit GATE_CAPTURE = 1'b1
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          wr_n,
   input  logic [AW-1:0] addr,
   input  logic [DW-1:0] wdata,
   input  logic [BW-1:0] bw_n,
   output logic          pend_v,
   output logic [AW-1:0] pend_a,
   output logic [DW-1:0] pend_d0,
   output logic [DW-1:0] pend_d1,
   output logic [BW-1:0] pend_m0,
   output logic [BW-1:0] pend_m1
);

   // rising-edge half: request flag, first word and its mask
   logic          go_q;
   logic [DW-1:0] d0_q;
   logic [BW-1:0] m0_q;
   // falling-edge half: write address, second word and its mask
   logic [AW-1:0] a_n;
   logic [DW-1:0] d1_n;
   logic [BW-1:0] m1_n;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) go_q <= 1'b0;
      else        go_q <= !wr_n;
   end

   generate
      if (GATE_CAPTURE) begin : g_gated
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               d0_q <= '0;
               m0_q <= '1;
            end else if (!wr_n) begin
               d0_q <= wdata;
               m0_q <= bw_n;
            end
         end
         always_ff @(negedge clk or negedge rst_n) begin
            if (!rst_n) begin
               a_n  <= '0;
               d1_n <= '0;
               m1_n <= '1;
            end else if (go_q) begin
               a_n  <= addr;
               d1_n <= wdata;
               m1_n <= bw_n;
            end
         end
      end else begin : g_free
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               d0_q <= '0;
               m0_q <= '1;
            end else begin
               d0_q <= wdata;
               m0_q <= bw_n;
            end
         end
         always_ff @(negedge clk or negedge rst_n) begin
            if (!rst_n) begin
               a_n  <= '0;
               d1_n <= '0;
               m1_n <= '1;
            end else begin
               a_n  <= addr;
               d1_n <= wdata;
               m1_n <= bw_n;
            end
         end
      end
   endgenerate

   // pending stage: the whole write, assembled one cycle after its request
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pend_v  <= 1'b0;
         pend_a  <= '0;
         pend_d0 <= '0;
         pend_d1 <= '0;
         pend_m0 <= '1;
         pend_m1 <= '1;
      end else begin
         pend_v  <= go_q;
         pend_a  <= a_n;
         pend_d0 <= d0_q;
         pend_d1 <= d1_n;
         pend_m0 <= m0_q;
         pend_m1 <= m1_n;
      end
   end

   // R4: a pending write exists only if wr_n was low at a rising edge two cycles back
   p_write_pipe_r4: assert property (@(posedge clk) disable iff (!rst_n)
      pend_v |-> $past(!wr_n, 2));

endmodule

// File: rtl/qdr_store.sv
module qdr_store
   import qdr_pkg::*;
#(
   parameter int unsigned AW = 8,
   parameter int unsigned DW = 18,
   parameter int unsigned BW = 2
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          rd_n,
   input  logic [AW-1:0] addr,
   input  logic          pend_v,
   input  logic [AW-1:0] pend_a,
   input  logic [DW-1:0] pend_d0,
   input  logic [DW-1:0] pend_d1,
   input  logic [BW-1:0] pend_m0,
   input  logic [BW-1:0] pend_m1,
   output logic          f_v,
   output logic [DW-1:0] f_w0,
   output logic [DW-1:0] f_w1
);

   localparam int unsigned DEPTH  = 1 << AW;
   localparam int unsigned LANE_W = DW / BW;
   localparam int unsigned LOC_W  = 2 * DW;

   logic [LOC_W-1:0] mem [DEPTH];

   logic          rd_go_q;
   logic [AW-1:0] rd_a_q;
   logic          hit;
   logic [LOC_W-1:0] base, cur;
   logic [DW-1:0] fw0, fw1, cw0, cw1;

   function automatic logic [DW-1:0] mix(input logic [DW-1:0] old_w,
                                         input logic [DW-1:0] new_w,
                                         input logic [BW-1:0] mask_n);
      lanes_t keep;
      keep = '1;
      keep[BW-1:0] = mask_n;
      return DW'(lane_merge(wide_t'(old_w), wide_t'(new_w), keep, LANE_W));
   endfunction

   // read address stage (rising edge)
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rd_go_q <= 1'b0;
         rd_a_q  <= '0;
      end else begin
         rd_go_q <= !rd_n;
         rd_a_q  <= addr;
      end
   end

   // commit of the pending write, merged lane by lane
   always_comb begin
      cur = mem[pend_a];
      cw0 = mix(cur[DW-1:0],     pend_d0, pend_m0);
      cw1 = mix(cur[LOC_W-1:DW], pend_d1, pend_m1);
   end

   always_ff @(posedge clk) begin
      if (pend_v) mem[pend_a] <= {cw1, cw0};
   end

   // fetch: array contents overlaid with the still-uncommitted write
   always_comb begin
      base = mem[rd_a_q];
      hit  = pend_v && (pend_a == rd_a_q);
      fw0  = base[DW-1:0];
      fw1  = base[LOC_W-1:DW];
      if (hit) begin
         fw0 = mix(fw0, pend_d0, pend_m0);
         fw1 = mix(fw1, pend_d1, pend_m1);
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         f_v  <= 1'b0;
         f_w0 <= '0;
         f_w1 <= '0;
      end else begin
         f_v  <= rd_go_q;
         f_w0 <= fw0;
         f_w1 <= fw1;
      end
   end

   // R2: a fetched burst traces back to a read request two rising edges earlier
   p_read_pipe_r2: assert property (@(posedge clk) disable iff (!rst_n)
      f_v |-> $past(!rd_n, 2));

   // R8: a cycle without a pending write leaves the fetch of an unchanged location stable
   p_idle_keeps_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (!pend_v && rd_go_q && $past(rd_go_q) && $stable(rd_a_q) && !$past(pend_v))
      |=> $stable({f_w1, f_w0}));

endmodule

// File: rtl/qdr_rd_launch.sv
module qdr_rd_launch #(
   parameter int unsigned DW = 18,
   parameter bit HOLD_IDLE = 1'b0
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          f_v,
   input  logic [DW-1:0] f_w0,
   input  logic [DW-1:0] f_w1,
   output logic [DW-1:0] rdata,
   output logic          rvalid,
   output logic          echo_p,
   output logic          echo_n
);

   logic [DW-1:0] q_neg, q_pos, idle_n, idle_p;
   logic          v_neg, v_pos;

   generate
      if (HOLD_IDLE) begin : g_hold
         assign idle_n = q_pos;
         assign idle_p = q_neg;
      end else begin : g_zero
         assign idle_n = '0;
         assign idle_p = '0;
      end
   endgenerate

   // first word launched on the falling edge
   always_ff @(negedge clk or negedge rst_n) begin
      if (!rst_n) begin
         v_neg <= 1'b0;
         q_neg <= '0;
      end else begin
         v_neg <= f_v;
         q_neg <= f_v ? f_w0 : idle_n;
      end
   end

   // second word launched on the following rising edge
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         v_pos <= 1'b0;
         q_pos <= '0;
      end else begin
         v_pos <= f_v;
         q_pos <= f_v ? f_w1 : idle_p;
      end
   end

   assign rdata  = clk ? q_pos : q_neg;
   assign rvalid = clk ? v_pos : v_neg;
   assign echo_p = clk;
   assign echo_n = ~clk;

   // R2: a second-word phase is always preceded by its first-word phase
   p_burst_pair_r2: assert property (@(negedge clk) disable iff (!rst_n)
      v_pos |-> v_neg);

endmodule

// File: rtl/qdr_b2_sram.sv
module qdr_b2_sram
   import qdr_pkg::*;
#(
   parameter int unsigned AW = 8,
   parameter int unsigned DW = 18,
   parameter int unsigned BW = 2,
   parameter bit GATE_CAPTURE = 1'b1,
   parameter bit HOLD_IDLE = 1'b0
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          rd_n,
   input  logic          wr_n,
   input  logic [AW-1:0] addr,
   input  logic [DW-1:0] wdata,
   input  logic [BW-1:0] bw_n,
   output logic [DW-1:0] rdata,
   output logic          rvalid,
   output logic          echo_p,
   output logic          echo_n
);

   generate
      if (BW == 0 || (DW % BW) != 0) begin : g_bad_lanes
         $error("word width must split evenly into byte lanes");
      end
      if (DW > MAX_W || BW > MAX_LANES) begin : g_bad_width
         $error("word or lane count exceeds package limits");
      end
      if (AW < 1 || AW > 12) begin : g_bad_depth
         $error("address width out of the supported model range");
      end
   endgenerate

   logic          pend_v;
   logic [AW-1:0] pend_a;
   logic [DW-1:0] pend_d0, pend_d1;
   logic [BW-1:0] pend_m0, pend_m1;
   logic          f_v;
   logic [DW-1:0] f_w0, f_w1;

   qdr_wr_capture #(
      .AW(AW), .DW(DW), .BW(BW), .GATE_CAPTURE(GATE_CAPTURE)
   ) u_wr (
      .clk(clk), .rst_n(rst_n), .wr_n(wr_n), .addr(addr), .wdata(wdata),
      .bw_n(bw_n), .pend_v(pend_v), .pend_a(pend_a), .pend_d0(pend_d0),
      .pend_d1(pend_d1), .pend_m0(pend_m0), .pend_m1(pend_m1)
   );

   qdr_store #(
      .AW(AW), .DW(DW), .BW(BW)
   ) u_store (
      .clk(clk), .rst_n(rst_n), .rd_n(rd_n), .addr(addr),
      .pend_v(pend_v), .pend_a(pend_a), .pend_d0(pend_d0), .pend_d1(pend_d1),
      .pend_m0(pend_m0), .pend_m1(pend_m1),
      .f_v(f_v), .f_w0(f_w0), .f_w1(f_w1)
   );

   qdr_rd_launch #(
      .DW(DW), .HOLD_IDLE(HOLD_IDLE)
   ) u_launch (
      .clk(clk), .rst_n(rst_n), .f_v(f_v), .f_w0(f_w0), .f_w1(f_w1),
      .rdata(rdata), .rvalid(rvalid), .echo_p(echo_p), .echo_n(echo_n)
   );

   generate
      if (!HOLD_IDLE) begin : g_idle_chk
         // R8: the low phase carries zeros whenever it holds no read word
         p_idle_bus_r8: assert property (@(posedge clk) disable iff (!rst_n)
            !rvalid |-> (rdata == '0));
      end
   endgenerate

endmodule

// File: tb/qdr_b2_sram_tb.sv
module qdr_b2_sram_tb;

   localparam int PERIOD = 10;
   localparam int NT     = 4096;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        rd_n = 1'b1;
   logic        wr_n = 1'b1;
   logic [7:0]  addr = '0;
   logic [17:0] wdata = '0;
   logic [1:0]  bw_n = '1;
   logic [17:0] rdata;
   logic        rvalid;
   logic        echo_p, echo_n;

   int checks = 0;
   int fails  = 0;
   int tick   = 0;
   bit checking = 1'b0;
   bit done = 1'b0;

   logic [35:0] sh [256];
   logic        lo_v [NT];
   logic [17:0] lo_d [NT];
   string       lo_t [NT];
   logic        hi_v [NT];
   logic [17:0] hi_d [NT];
   string       hi_t [NT];

   always #(PERIOD/2) clk = ~clk;
   always @(posedge clk) tick <= tick + 1;

   qdr_b2_sram u_dut (
      .clk(clk), .rst_n(rst_n), .rd_n(rd_n), .wr_n(wr_n), .addr(addr),
      .wdata(wdata), .bw_n(bw_n), .rdata(rdata), .rvalid(rvalid),
      .echo_p(echo_p), .echo_n(echo_n)
   );

   function automatic logic [17:0] pat(input int a, input int k);
      return 18'((a * 523 + k * 7919 + 11) ^ (a << 9));
   endfunction

   // R5: lane i = bits [9i+8:9i], written when mask bit i is 0
   function automatic logic [17:0] merge(input logic [17:0] o, input logic [17:0] n,
                                         input logic [1:0] m);
      logic [17:0] r;
      r = o;
      for (int i = 0; i < 2; i++) if (!m[i]) r[i*9 +: 9] = n[i*9 +: 9];
      return r;
   endfunction

   task automatic compare(input string tag, input logic av, input logic ev,
                          input logic [17:0] ad, input logic [17:0] ed);
      checks++;
      if (av !== ev || ad !== ed) begin
         fails++;
         $display("FAIL %s: actual valid=%0b data=%h expected valid=%0b data=%h",
                  tag, av, ad, ev, ed);
      end
   endtask

   task automatic echo_chk(input logic ep);
      checks++;
      if (echo_p !== ep || echo_n !== ~ep) begin
         fails++;
         $display("FAIL R9: actual echo_p=%0b echo_n=%0b expected %0b/%0b",
                  echo_p, echo_n, ep, ~ep);
      end
   endtask

   // high phase after rising edge number tick
   always begin
      @(posedge clk); #3;
      if (checking && tick < NT) begin
         compare(hi_t[tick] == "" ? "R8" : hi_t[tick], rvalid, hi_v[tick], rdata, hi_d[tick]);
         echo_chk(1'b1);
      end
   end

   // low phase after rising edge number tick
   always begin
      @(negedge clk); #3;
      if (checking && tick < NT) begin
         compare(lo_t[tick] == "" ? "R8" : lo_t[tick], rvalid, lo_v[tick], rdata, lo_d[tick]);
         echo_chk(1'b0);
      end
   end

   task automatic cyc(input bit rd, input int ra, input bit wr, input int wa,
                      input logic [17:0] d0, input logic [1:0] m0,
                      input logic [17:0] d1, input logic [1:0] m1,
                      input bit noise, input string tag);
      int t;
      @(negedge clk); #1;
      rd_n  = !rd;
      wr_n  = !wr;
      addr  = 8'(ra);
      wdata = d0;
      bw_n  = m0;
      t = tick + 1;
      if (t + 2 < NT) begin
         if (rd) begin
            lo_v[t+1] = 1'b1; lo_d[t+1] = sh[ra][17:0];  lo_t[t+1] = tag;
            hi_v[t+2] = 1'b1; hi_d[t+2] = sh[ra][35:18]; hi_t[t+2] = tag;
         end else if (tag != "") begin
            if (!lo_v[t+1]) lo_t[t+1] = tag;
            if (!hi_v[t+2]) hi_t[t+2] = tag;
         end
      end
      if (wr) sh[wa] = {merge(sh[wa][35:18], d1, m1), merge(sh[wa][17:0], d0, m0)};
      @(posedge clk); #1;
      addr  = 8'(wa);
      wdata = d1;
      bw_n  = m1;
      if (noise) begin
         rd_n = 1'b0;
         wr_n = 1'b0;
      end
   endtask

   task automatic idle(input string tag);
      cyc(1'b0, 0, 1'b0, 0, 18'h0, 2'b11, 18'h0, 2'b11, 1'b0, tag);
   endtask

   task automatic summary();
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
   endtask

   initial begin
      for (int i = 0; i < NT; i++) begin
         lo_v[i] = 1'b0; lo_d[i] = '0; lo_t[i] = "";
         hi_v[i] = 1'b0; hi_d[i] = '0; hi_t[i] = "";
      end
      // R1: outputs idle while reset is held
      repeat (3) @(posedge clk);
      #3 compare("R1", rvalid, 1'b0, rdata, 18'h0);
      @(negedge clk); #3 compare("R1", rvalid, 1'b0, rdata, 18'h0);
      @(negedge clk); #1 rst_n = 1'b1;
      checking = 1'b1;
      idle("R1");
      idle("R1");

      // fill every location with full masks
      for (int a = 0; a < 256; a++)
         cyc(1'b0, 0, 1'b1, a, pat(a, 0), 2'b00, pat(a, 1), 2'b00, 1'b0, "R1");
      idle("R8");
      idle("R8");

      // R10 / R2: back-to-back read sweep of all locations
      for (int a = 0; a < 256; a++)
         cyc(1'b1, a, 1'b0, 0, 18'h0, 2'b11, 18'h0, 2'b11, 1'b0, "R10");
      repeat (3) idle("R8");

      // R2: isolated reads
      for (int a = 0; a < 8; a++) begin
         cyc(1'b1, a * 31, 1'b0, 0, 18'h0, 2'b11, 18'h0, 2'b11, 1'b0, "R2");
         idle("R2");
         idle("R2");
      end

      // R3: read one location, write another in the same cycle
      for (int a = 0; a < 64; a++)
         cyc(1'b1, a, 1'b1, a + 128, pat(a, 5), 2'b00, pat(a, 6), 2'b00, 1'b0, "R3");
      for (int a = 128; a < 192; a++)
         cyc(1'b1, a, 1'b0, 0, 18'h0, 2'b11, 18'h0, 2'b11, 1'b0, "R3");

      // R6 then R7: same-cycle hazard, then next-cycle forwarding
      for (int a = 64; a < 96; a++) begin
         cyc(1'b1, a, 1'b1, a, pat(a, 8), 2'b00, pat(a, 9), 2'b00, 1'b0, "R6");
         cyc(1'b1, a, 1'b0, 0, 18'h0, 2'b11, 18'h0, 2'b11, 1'b0, "R7");
      end

      // R5 with R7: every mask pair, forwarded read next cycle
      for (int a = 0; a < 16; a++) begin
         cyc(1'b0, 0, 1'b1, 200 + a, pat(a, 12), 2'(a), pat(a, 13), 2'(a >> 2), 1'b0, "R5");
         cyc(1'b1, 200 + a, 1'b0, 0, 18'h0, 2'b11, 18'h0, 2'b11, 1'b0, "R7");
      end
      repeat (3) idle("R5");
      for (int a = 0; a < 16; a++)
         cyc(1'b1, 200 + a, 1'b0, 0, 18'h0, 2'b11, 18'h0, 2'b11, 1'b0, "R5");

      // R4: enables low only in the high phase start nothing
      for (int a = 0; a < 8; a++)
         cyc(1'b0, 10 + a, 1'b0, 10 + a, pat(a, 20), 2'b00, pat(a, 21), 2'b00, 1'b1, "R4");
      repeat (3) idle("R4");
      for (int a = 0; a < 8; a++)
         cyc(1'b1, 10 + a, 1'b0, 0, 18'h0, 2'b11, 18'h0, 2'b11, 1'b0, "R4");

      // R8: idle cycles with busy address and data change nothing
      for (int a = 0; a < 8; a++)
         cyc(1'b0, 20 + a, 1'b0, 20 + a, pat(a, 30), 2'b00, pat(a, 31), 2'b00, 1'b0, "R8");
      for (int a = 0; a < 8; a++)
         cyc(1'b1, 20 + a, 1'b0, 0, 18'h0, 2'b11, 18'h0, 2'b11, 1'b0, "R8");
      repeat (4) idle("R8");

      done = 1'b1;
      summary();
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         fails++;
         $display("FAIL R2: watchdog expired, actual tick %0d expected completion", tick);
         summary();
         $finish;
      end
   end

endmodule